// File: doc/BRIEF.md
# Two-Channel One-Time-Programmable Wiper Preset Controller

This block holds the digital state behind a dual 8-bit digital potentiometer whose power-up setting can be fixed once by fusing. A serial front end decodes each command into a channel select, a data code and three control bits: shutdown, program and overwrite. It hands the command over as a single-cycle strobe. The block keeps one wiper register per channel and one preset register per channel standing in for the fuse array. It drives every channel's wiper code, a common shutdown flag and a two-bit validation status. While a programming attempt runs, it also raises a fuse-blow enable for a fixed number of clock cycles.

Two reset inputs separate two kinds of event. `arst_n_i` models a brand-new die with every fuse intact, and it clears everything. `rst_n_i` models a power cycle. It reloads the wipers from the presets, which read midscale 0x80 until a programming attempt has passed, and it clears shutdown. It leaves the programming result alone. Before programming, writes change the wiper freely. After the single permitted attempt, writes are locked and can move a wiper only through the overwrite bit. A write with overwrite cleared snaps both wipers back to their presets.

The sequencer has four states:
- ST_BLANK: no attempt has been made yet.
- ST_BLOW: the fuse interval is running.
- ST_PASS: the attempt was reported good.
- ST_FAIL: the attempt was reported bad or was interrupted.

Its transitions are the following. ST_BLANK goes to ST_BLOW on a program command. ST_BLOW goes to ST_PASS or ST_FAIL on the last cycle of the interval, depending on `fuse_ok_i`. A soft reset during ST_BLOW sends the sequencer to ST_FAIL. ST_PASS and ST_FAIL never leave, except through `arst_n_i`.

Top module: `otp_preset_ctrl`

## Requirements
- R1: After `arst_n_i`, every wiper code is 0x80, `shdn_o` is 0, `valid_o` is 00, and `busy_o` and `fuse_blow_en_o` are 0.
- R2: With no programming attempt made, a command with program = 0 writes `cmd_data_i` into the wiper selected by `cmd_chan_i` (0 selects bits 7:0 of `wiper_o`, 1 selects bits 15:8), visible the cycle after the strobe. The other wiper is unchanged, the overwrite bit has no effect, and any number of writes is accepted.
- R3: A program command in ST_BLANK raises `busy_o` and `fuse_blow_en_o` together from the next cycle for exactly PROG_CYCLES cycles and leaves both wipers unchanged.
- R4: Any command strobed while `busy_o` is 1 changes no wiper code and not the shutdown flag.
- R5: `valid_o` (bit 1 = E1, bit 0 = E0) reads 00 in ST_BLANK and ST_BLOW. It becomes 11 after the interval if `fuse_ok_i` is 1 on the last busy cycle, and 10 otherwise, and then keeps that value.
- R6: A program command after the first attempt starts nothing: `busy_o` stays 0 and `valid_o` keeps its value. The command is handled as an ordinary locked write.
- R7: After an attempt, a write with overwrite = 1 loads the selected wiper. A write with overwrite = 0 loads every wiper with its preset and ignores the data.
- R8: A soft reset loads every wiper with its preset. The preset is the code fused by a passing attempt, or 0x80 if no attempt has passed. `valid_o` is preserved.
- R9: Every accepted command that is not a starting program command copies its shutdown bit to `shdn_o` on the next cycle without altering any wiper code beyond what R2 or R7 prescribe. Soft reset clears `shdn_o`.
- R10: A soft reset while `busy_o` is 1 ends the attempt with `valid_o` = 10 and `busy_o` = 0, and the presets stay 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_n_i | input | 1 | Asynchronous fresh-die reset, active low; also clears fuse state |
| rst_n_i | input | 1 | Synchronous power-cycle reset, active low; fuse state kept |
| cmd_valid_i | input | 1 | One-cycle strobe of a decoded command |
| cmd_chan_i | input | CH_W (1) | Channel select |
| cmd_data_i | input | CODE_W (8) | Wiper code |
| cmd_shdn_i | input | 1 | Shutdown bit |
| cmd_prog_i | input | 1 | Program request bit |
| cmd_ovr_i | input | 1 | Overwrite bit |
| fuse_ok_i | input | 1 | Pass/fail report of the fuse array model, sampled on the last busy cycle |
| fuse_blow_en_o | output | 1 | Fuse-blow enable |
| busy_o | output | 1 | Programming interval running |
| shdn_o | output | 1 | Shutdown flag |
| valid_o | output | 2 | Validation status {E1,E0} |
| wiper_o | output | NUM_CH*CODE_W (16) | Wiper codes, channel 0 in the low byte |

## Verification
The assertions assume that `cmd_valid_i` is a single-cycle strobe and that `cmd_chan_i` names an existing channel whenever it is high. They also assume that `fuse_ok_i` is settled by the last cycle of the interval and that `rst_n_i` is synchronous to the clock. The stimulus drives every input on the falling edge. It holds `fuse_ok_i` constant through each attempt and only ever selects channels 0 and 1. It raises each reset for a whole cycle, so no edge sees a half-applied command or reset.

// File: rtl/otp_preset_pkg.sv
package otp_preset_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_BLOW  = 2'd1,
        ST_PASS  = 2'd2,
        ST_FAIL  = 2'd3
    } otp_state_e;

    localparam logic [1:0] VAL_BLANK = 2'b00;
    localparam logic [1:0] VAL_PASS  = 2'b11;
    localparam logic [1:0] VAL_FAIL  = 2'b10;

endpackage

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
    import otp_preset_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 40000000,
    localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
    input  logic       clk_i,
    input  logic       arst_n_i,
    input  logic       rst_n_i,
    input  logic       start_i,
    input  logic       fuse_ok_i,
    output logic       busy_o,
    output logic       blow_en_o,
    output logic       locked_o,
    output logic       commit_o,
    output logic [1:0] valid_o
);

    otp_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic last;

    assign last = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (start_i) state_d = ST_BLOW;
            ST_BLOW:  if (last) state_d = fuse_ok_i ? ST_PASS : ST_FAIL;
            ST_PASS:  state_d = ST_PASS;
            ST_FAIL:  state_d = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            state_q <= ST_BLANK;
        end else if (!rst_n_i) begin
            state_q <= (state_q == ST_BLOW) ? ST_FAIL : state_q;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            cnt_q <= '0;
        end else if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (state_q == ST_BLANK && start_i) begin
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
        end else if (state_q == ST_BLOW && !last) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy_o    = 1'b0;
        blow_en_o = 1'b0;
        locked_o  = 1'b0;
        valid_o   = VAL_BLANK;
        unique case (state_q)
            ST_BLANK: ;
            ST_BLOW: begin
                busy_o    = 1'b1;
                blow_en_o = 1'b1;
            end
            ST_PASS: begin
                locked_o = 1'b1;
                valid_o  = VAL_PASS;
            end
            ST_FAIL: begin
                locked_o = 1'b1;
                valid_o  = VAL_FAIL;
            end
        endcase
    end

    assign commit_o = (state_q == ST_BLOW) && last && fuse_ok_i && rst_n_i;

    // R3
    busy_len_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        (busy_o && !last) |=> busy_o);

    // R5
    valid_busy_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        busy_o |-> (valid_o == VAL_BLANK));

    // R5
    pass_sticky_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (valid_o == VAL_PASS) |=> (valid_o == VAL_PASS));

    // R6
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        locked_o |=> (locked_o && !busy_o));

    // R10
    reset_abort_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (busy_o && !rst_n_i) |=> (valid_o == VAL_FAIL));

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned NUM_CH = 2
) (
    input  logic                     clk_i,
    input  logic                     arst_n_i,
    input  logic                     commit_i,
    input  logic [NUM_CH*CODE_W-1:0] capture_i,
    output logic [NUM_CH*CODE_W-1:0] preset_o
);

    localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fuse
        logic [CODE_W-1:0] fused_q;
        always_ff @(posedge clk_i or negedge arst_n_i) begin
            if (!arst_n_i) begin
                fused_q <= MIDSCALE;
            end else if (commit_i) begin
                fused_q <= capture_i[c*CODE_W +: CODE_W];
            end
        end
        assign preset_o[c*CODE_W +: CODE_W] = fused_q;
    end

    // R8
    preset_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        !commit_i |=> $stable(preset_o));

endmodule

// File: rtl/otp_wiper_chan.sv
module otp_wiper_chan #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk_i,
    input  logic              arst_n_i,
    input  logic              rst_n_i,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_data_i,
    input  logic              revert_i,
    input  logic [CODE_W-1:0] preset_i,
    output logic [CODE_W-1:0] wiper_o
);

    localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] wiper_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            wiper_q <= MIDSCALE;
        end else if (!rst_n_i) begin
            wiper_q <= preset_i;
        end else if (wr_en_i) begin
            wiper_q <= wr_data_i;
        end else if (revert_i) begin
            wiper_q <= preset_i;
        end
    end

    assign wiper_o = wiper_q;

    // R7
    revert_load_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        (revert_i && !wr_en_i) |=> (wiper_o == $past(preset_i)));

    // R8
    reset_load_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        !rst_n_i |=> (wiper_o == $past(preset_i)));

endmodule

// File: rtl/otp_preset_ctrl.sv
module otp_preset_ctrl
    import otp_preset_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned PROG_CYCLES = 40000000,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     arst_n_i,
    input  logic                     rst_n_i,
    input  logic                     cmd_valid_i,
    input  logic [CH_W-1:0]          cmd_chan_i,
    input  logic [CODE_W-1:0]        cmd_data_i,
    input  logic                     cmd_shdn_i,
    input  logic                     cmd_prog_i,
    input  logic                     cmd_ovr_i,
    input  logic                     fuse_ok_i,
    output logic                     fuse_blow_en_o,
    output logic                     busy_o,
    output logic                     shdn_o,
    output logic [1:0]               valid_o,
    output logic [NUM_CH*CODE_W-1:0] wiper_o
);

    logic busy, locked, commit;
    logic cmd_ok, start, plain;
    logic shdn_q;
    logic [NUM_CH*CODE_W-1:0] preset;
    logic [NUM_CH-1:0] wr_en, revert;

    assign cmd_ok = cmd_valid_i && !busy;
    assign start  = cmd_ok && cmd_prog_i && !locked;
    assign plain  = cmd_ok && !start;

    otp_seq_fsm #(
        .PROG_CYCLES(PROG_CYCLES)
    ) seq_i (
        .clk_i     (clk_i),
        .arst_n_i  (arst_n_i),
        .rst_n_i   (rst_n_i),
        .start_i   (start),
        .fuse_ok_i (fuse_ok_i),
        .busy_o    (busy),
        .blow_en_o (fuse_blow_en_o),
        .locked_o  (locked),
        .commit_o  (commit),
        .valid_o   (valid_o)
    );

    otp_fuse_store #(
        .CODE_W(CODE_W),
        .NUM_CH(NUM_CH)
    ) fuse_i (
        .clk_i     (clk_i),
        .arst_n_i  (arst_n_i),
        .commit_i  (commit),
        .capture_i (wiper_o),
        .preset_o  (preset)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign wr_en[c]  = plain && (cmd_chan_i == CH_W'(c)) && (!locked || cmd_ovr_i);
        assign revert[c] = plain && locked && !cmd_ovr_i;

        otp_wiper_chan #(
            .CODE_W(CODE_W)
        ) chan_i (
            .clk_i     (clk_i),
            .arst_n_i  (arst_n_i),
            .rst_n_i   (rst_n_i),
            .wr_en_i   (wr_en[c]),
            .wr_data_i (cmd_data_i),
            .revert_i  (revert[c]),
            .preset_i  (preset[c*CODE_W +: CODE_W]),
            .wiper_o   (wiper_o[c*CODE_W +: CODE_W])
        );
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            shdn_q <= 1'b0;
        end else if (!rst_n_i) begin
            shdn_q <= 1'b0;
        end else if (plain) begin
            shdn_q <= cmd_shdn_i;
        end
    end

    assign shdn_o = shdn_q;
    assign busy_o = busy;

    // R4
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        busy_o |=> ($stable(wiper_o) && $stable(shdn_o)));

    // R2
    open_write_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        (cmd_valid_i && !cmd_prog_i && valid_o == VAL_BLANK && !busy_o && cmd_chan_i == '0)
        |=> (wiper_o[CODE_W-1:0] == $past(cmd_data_i)));

    // R3
    start_blow_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        (cmd_valid_i && cmd_prog_i && !busy_o && valid_o == VAL_BLANK)
        |=> (fuse_blow_en_o && $stable(wiper_o)));

    // R9
    shdn_copy_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i || !rst_n_i)
        (cmd_valid_i && !busy_o && (valid_o != VAL_BLANK || !cmd_prog_i))
        |=> (shdn_o == $past(cmd_shdn_i)));

endmodule

// File: tb/otp_preset_ctrl_tb_top.sv
module otp_preset_ctrl_tb_top;

    localparam int unsigned PROG = 20;

    typedef struct {
        string      tag;
        logic [7:0] w0;
        logic [7:0] w1;
        logic       shdn;
        logic [1:0] val;
        logic       busy;
    } exp_t;

    logic clk = 1'b0;
    logic arst_n = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_chan = 1'b0, cmd_shdn = 1'b0, cmd_prog = 1'b0, cmd_ovr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic fuse_ok = 1'b1;
    logic blow_en, busy, shdn;
    logic [1:0] val;
    logic [15:0] wiper;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    otp_preset_ctrl #(.CODE_W(8), .NUM_CH(2), .PROG_CYCLES(PROG)) dut_i (
        .clk_i(clk), .arst_n_i(arst_n), .rst_n_i(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_chan_i(cmd_chan), .cmd_data_i(cmd_data),
        .cmd_shdn_i(cmd_shdn), .cmd_prog_i(cmd_prog), .cmd_ovr_i(cmd_ovr),
        .fuse_ok_i(fuse_ok), .fuse_blow_en_o(blow_en), .busy_o(busy),
        .shdn_o(shdn), .valid_o(val), .wiper_o(wiper)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic expect_out(input string tag, input logic [7:0] w0, input logic [7:0] w1,
                              input logic s, input logic [1:0] v, input logic b);
        exp_t e;
        e.tag = tag; e.w0 = w0; e.w1 = w1; e.shdn = s; e.val = v; e.busy = b;
        q.push_back(e);
    endtask

    // monitor: compares queued expectations on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({wiper[15:8], wiper[7:0], shdn, val, busy, blow_en} ==
                      {e.w1, e.w0, e.shdn, e.val, e.busy, e.busy}, e.tag,
                      {wiper, 3'b0, shdn, 2'b0, val, 3'b0, busy},
                      {e.w1, e.w0, 3'b0, e.shdn, 2'b0, e.val, 3'b0, e.busy});
            end
        end
    end

    task automatic send(input logic ch, input logic [7:0] d, input logic s,
                        input logic p, input logic o);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_chan = ch; cmd_data = d;
        cmd_shdn = s; cmd_prog = p; cmd_ovr = o;
        @(posedge clk);
        #1 cmd_valid = 1'b0; cmd_prog = 1'b0;
    endtask

    task automatic soft_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic release_soft();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fresh_die();
        @(negedge clk);
        arst_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        arst_n = 1'b1; rst_n = 1'b1;
    endtask

    // counts busy cycles after a program command; optionally injects a write
    task automatic run_interval(input string tag, output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            check(blow_en == 1'b1, {tag, " R3 blow_en with busy"}, blow_en, 1);
            check(val == 2'b00, {tag, " R5 valid 00 while busy"}, val, 0);
            if (n == 3) begin
                cmd_valid = 1'b1; cmd_chan = 1'b0; cmd_data = 8'h11;
                cmd_shdn = 1'b1; cmd_ovr = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            if (n > PROG + 5) break;
        end
        cmd_valid = 1'b0; cmd_shdn = 1'b0;
    endtask

    initial begin
        int n;
        fresh_die();
        @(posedge clk); #1;
        expect_out("R1 reset state", 8'h80, 8'h80, 0, 2'b00, 0);

        send(0, 8'h12, 0, 0, 0); expect_out("R2 ch0 write", 8'h12, 8'h80, 0, 2'b00, 0);
        send(1, 8'hF0, 0, 0, 1); expect_out("R2 ch1 write ovr ignored", 8'h12, 8'hF0, 0, 2'b00, 0);
        send(0, 8'h34, 0, 0, 0); expect_out("R2 rewrite ch0", 8'h34, 8'hF0, 0, 2'b00, 0);
        send(1, 8'h55, 1, 0, 0); expect_out("R9 shdn set with write", 8'h34, 8'h55, 1, 2'b00, 0);
        send(0, 8'h34, 0, 0, 0); expect_out("R9 shdn cleared", 8'h34, 8'h55, 0, 2'b00, 0);
        send(0, 8'h34, 1, 0, 0);
        soft_reset(); expect_out("R8 unprogrammed soft reset", 8'h80, 8'h80, 0, 2'b00, 0);
        release_soft();

        send(0, 8'hA5, 0, 0, 0);
        send(1, 8'h3C, 0, 0, 0); expect_out("R2 pre-program", 8'hA5, 8'h3C, 0, 2'b00, 0);

        fuse_ok = 1'b1;
        send(0, 8'h00, 0, 1, 0); expect_out("R3 program start", 8'hA5, 8'h3C, 0, 2'b00, 1);
        run_interval("pass", n);
        check(n == PROG, "R3 busy length", n, PROG);
        expect_out("R4 R5 after pass", 8'hA5, 8'h3C, 0, 2'b11, 0);

        send(0, 8'h77, 0, 0, 0); expect_out("R7 locked write no ovr", 8'hA5, 8'h3C, 0, 2'b11, 0);
        send(0, 8'h77, 0, 0, 1); expect_out("R7 ovr ch0", 8'h77, 8'h3C, 0, 2'b11, 0);
        send(1, 8'h01, 0, 0, 1); expect_out("R7 ovr ch1", 8'h77, 8'h01, 0, 2'b11, 0);
        send(1, 8'h99, 0, 0, 0); expect_out("R7 revert both", 8'hA5, 8'h3C, 0, 2'b11, 0);

        send(0, 8'h42, 0, 1, 1); expect_out("R6 second program ignored", 8'h42, 8'h3C, 0, 2'b11, 0);
        @(posedge clk); #1;
        expect_out("R6 still idle", 8'h42, 8'h3C, 0, 2'b11, 0);

        send(1, 8'h66, 0, 0, 1); expect_out("R7 ovr before reset", 8'h42, 8'h66, 0, 2'b11, 0);
        soft_reset(); expect_out("R8 fused reload", 8'hA5, 8'h3C, 0, 2'b11, 0);
        release_soft();

        send(0, 8'h10, 1, 0, 1); expect_out("R9 shdn locked", 8'h10, 8'h3C, 1, 2'b11, 0);
        send(0, 8'h10, 0, 0, 0); expect_out("R9 R7 shdn off revert", 8'hA5, 8'h3C, 0, 2'b11, 0);

        fresh_die();
        @(posedge clk); #1;
        expect_out("R1 fresh die", 8'h80, 8'h80, 0, 2'b00, 0);
        send(0, 8'h20, 0, 0, 0);
        fuse_ok = 1'b0;
        send(0, 8'h00, 0, 1, 0); expect_out("R3 fail start", 8'h20, 8'h80, 0, 2'b00, 1);
        run_interval("fail", n);
        check(n == PROG, "R3 busy length fail", n, PROG);
        expect_out("R5 fail status", 8'h20, 8'h80, 0, 2'b10, 0);
        soft_reset(); expect_out("R8 after fail", 8'h80, 8'h80, 0, 2'b10, 0);
        release_soft();
        fuse_ok = 1'b1;
        send(0, 8'h00, 0, 1, 1); expect_out("R6 retry after fail", 8'h00, 8'h80, 0, 2'b10, 0);

        fresh_die();
        send(1, 8'hC3, 0, 0, 0);
        send(0, 8'h00, 0, 1, 0); expect_out("R3 start abort run", 8'h80, 8'hC3, 0, 2'b00, 1);
        repeat (4) @(posedge clk);
        soft_reset(); expect_out("R10 aborted", 8'h80, 8'h80, 0, 2'b10, 0);
        release_soft();
        repeat (PROG + 2) @(posedge clk); #1;
        expect_out("R10 stays failed", 8'h80, 8'h80, 0, 2'b10, 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule